// File: doc/BRIEF.md
# Linear Systolic Bit-Serial Multiplier

This block multiplies an N-bit parallel operand by an N-bit serial operand and returns the full 2N-bit product one bit per clock, least significant bit first. The parallel operand and the operand format (unsigned or two's complement) are sampled in the cycle that carries a start pulse. The serial operand enters on a one-bit input, starting with its least significant bit in that same cycle. The product then leaves on a one-bit output. A strobe marks its first bit.

The datapath is a linear chain of ceil(N/2) identical cells. Each cell owns two adjacent bits of the parallel operand and forms two one-bit products per clock. It folds both into the partial sum of one weight that is passing through it, and keeps its own carry locally. Serial bits, operand bits, markers and partial sums all move only between neighbouring cells through registers, so no signal fans out along the chain. When N is odd, the parallel operand is widened by one bit: zero in unsigned mode, a copy of the sign in signed mode. In signed mode the top bit of the widened operand is subtracted, not added, in the last cell. A new operation may start every 2N clocks with no idle cycle between operations.

Top module: `sysmul_array`

## Requirements
- R1: With signed_i low at start, the 2N bits that follow the first-bit strobe, one per clock and least significant first, equal the unsigned product of a_i and the serial operand.
- R2: With signed_i high at start, those 2N bits equal the two's complement product of both operands read as signed N-bit values.
- R3: prod_first_o is high for exactly one cycle per operation. That cycle follows the ceil(N/2)-th rising edge after the edge that sampled start_i, and prod_bit_o carries product bit 0 in that cycle.
- R4: Operations started exactly 2N clocks apart each produce their correct product, with no idle output cycle between them and no influence of one operation on the next.
- R5: Of the 2N serial-input slots in an operation (slot 0 is the start cycle), only slots 0 to N-1 are used. The values on b_i in slots N to 2N-1 have no effect on the product.
- R6: a_i and signed_i are used only in the start cycle. Their values in the other cycles of an operation have no effect on the product.
- R7: Odd N gives correct unsigned and signed products in ceil(N/2) cells.
- R8: While rst is high and after its release, prod_bit_o and prod_first_o are 0 until an operation delivers its first bit.
- R9: Each cell's carry stays between 0 and 2, and the last cell's carry stays between -1 and 2.
- R10: Consecutive start pulses are at least 2N clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Marks slot 0 of a new operation |
| signed_i | input | 1 | 1 = two's complement, 0 = unsigned; sampled at start |
| a_i | input | N | Parallel operand; sampled at start |
| b_i | input | 1 | Serial operand bit, least significant first from the start cycle |
| prod_bit_o | output | 1 | Product bit, least significant first |
| prod_first_o | output | 1 | High with product bit 0 |

## Verification
On every cycle the assertions check several internal properties. They check the bounded range of each cell's carry. They check that a serial head marker reaches a cell only after that cell has seen the matching partial-sum start. They check the fixed latency and one-cycle width of the first-bit strobe, and that the operands and format arriving at the chain's tail still match the values captured at start. They also check the minimum spacing of start pulses. Only the bench scenarios can show that the emitted bits form the right product. Those scenarios cover unsigned and signed extremes, back-to-back operations, noise driven into the ignored serial slots and operand inputs, and an odd operand width.

// File: rtl/sysmul_pkg.sv
package sysmul_pkg;

  // Signed per-cell carry: 0..2 in ordinary cells, -1..2 in the last cell.
  typedef logic signed [2:0] carry_t;

  // Serial-operand lane: moves three registers per cell.
  typedef struct packed {
    logic bit_v;
    logic head;
  } bline_t;

  // Partial-sum lane: moves one register per cell.
  typedef struct packed {
    logic sum;
    logic first;
    logic mode;
  } sline_t;

endpackage

// File: rtl/sysmul_feed.sv
module sysmul_feed
  import sysmul_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [N-1:0] a_i,
  input  logic         b_i,
  output bline_t       fe_o,
  output logic         fe_mode_o,
  output logic [W-1:0] fe_a_o
);

  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;
  logic          taking;
  logic          mode_q;
  logic          msb_q;
  logic          mode_now;
  logic          bit_sel;
  logic [W-1:0]  a_pad;

  // Widen the parallel operand to an even width when N is odd.
  generate
    if (W > N) begin : g_pad
      assign a_pad = {signed_i & a_i[N-1], a_i};
    end else begin : g_nopad
      assign a_pad = a_i;
    end
  endgenerate

  always_comb begin
    idx      = start_i ? '0 : cnt_q;
    taking   = start_i || (cnt_q < CW'(N));
    mode_now = start_i ? signed_i : mode_q;
    // After N live bits, repeat the sign (signed) or feed zeros (unsigned).
    bit_sel  = taking ? b_i : (mode_q & msb_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CW'(N);
      mode_q <= 1'b0;
      msb_q  <= 1'b0;
      fe_o   <= '0;
      fe_a_o <= '0;
    end else begin
      cnt_q  <= start_i ? CW'(1) : (taking ? cnt_q + 1'b1 : cnt_q);
      mode_q <= mode_now;
      if (taking && idx == CW'(N - 1)) msb_q <= b_i;
      fe_o   <= '{bit_v: bit_sel, head: start_i};
      if (start_i) fe_a_o <= a_pad;
    end
  end

  assign fe_mode_o = mode_q;

endmodule

// File: rtl/sysmul_cell.sv
module sysmul_cell
  import sysmul_pkg::*;
#(
  parameter int W    = 8,
  parameter int J    = 0,
  parameter bit LAST = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  sline_t       s_in,
  input  bline_t       b_in,
  input  logic [W-1:0] a_in,
  output sline_t       s_out,
  output bline_t       b_out,
  output logic [W-1:0] a_out
);

  bline_t            d0, d1, d2;
  carry_t            carry_q;
  carry_t            c_eff;
  logic              live0_q, live1_q;
  logic [1:0]        pair_q, pair_now;
  logic              mode_q, mode_now;
  logic              use0, use1, t0, t1, neg;
  logic signed [3:0] t1_term, tot;

  always_comb begin
    pair_now = s_in.first ? a_in[2*J +: 2] : pair_q;
    mode_now = s_in.first ? s_in.mode : mode_q;
    c_eff    = s_in.first ? carry_t'(0) : carry_q;
    // Serial bits still belonging to the previous operation are masked
    // until this operation's head marker reaches the tap.
    use0     = b_in.head | (live0_q & ~s_in.first);
    use1     = d0.head   | (live1_q & ~s_in.first);
    t0       = pair_now[0] & b_in.bit_v & use0;
    t1       = pair_now[1] & d0.bit_v & use1;
    neg      = LAST && mode_now;
    t1_term  = neg ? -$signed({3'b000, t1}) : $signed({3'b000, t1});
    tot      = $signed({3'b000, s_in.sum}) + $signed({3'b000, t0})
             + t1_term + $signed({c_eff[2], c_eff});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d0      <= '0;
      d1      <= '0;
      d2      <= '0;
      carry_q <= '0;
      live0_q <= 1'b0;
      live1_q <= 1'b0;
      pair_q  <= '0;
      mode_q  <= 1'b0;
      s_out   <= '0;
      a_out   <= '0;
    end else begin
      d0      <= b_in;
      d1      <= d0;
      d2      <= d1;
      carry_q <= tot[3:1];
      live0_q <= b_in.head ? 1'b1 : (s_in.first ? 1'b0 : live0_q);
      live1_q <= d0.head   ? 1'b1 : (s_in.first ? 1'b0 : live1_q);
      pair_q  <= pair_now;
      mode_q  <= mode_now;
      s_out   <= '{sum: tot[0], first: s_in.first, mode: s_in.mode};
      a_out   <= a_in;
    end
  end

  assign b_out = d2;

  // R9: carry never leaves its bounded range
  generate
    if (LAST) begin : g_chk_last
      a_r9_carry_range_last: assert property (@(posedge clk) disable iff (rst)
        (carry_q >= -3'sd1) && (carry_q <= 3'sd2));
    end else begin : g_chk_mid
      a_r9_carry_range: assert property (@(posedge clk) disable iff (rst)
        (carry_q >= 3'sd0) && (carry_q <= 3'sd2));
    end
  endgenerate

  // R4: a serial head arrives only after this cell saw the matching sum start
  a_r4_head_after_first: assert property (@(posedge clk) disable iff (rst)
    b_in.head |-> (s_in.first || !live0_q));

endmodule

// File: rtl/sysmul_array.sv
module sysmul_array
  import sysmul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [N-1:0] a_i,
  input  logic         b_i,
  output logic         prod_bit_o,
  output logic         prod_first_o
);

  localparam int C   = (N + 1) / 2;
  localparam int W   = 2 * C;
  localparam int LIM = 2 * N;
  localparam int SW  = $clog2(LIM + 1);

  bline_t       fe_b;
  logic         fe_mode;
  logic [W-1:0] fe_a;

  sline_t       s_ch [C+1];
  bline_t       b_ch [C+1];
  logic [W-1:0] a_ch [C+1];

  sysmul_feed #(.N(N), .W(W)) feed_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .signed_i  (signed_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .fe_o      (fe_b),
    .fe_mode_o (fe_mode),
    .fe_a_o    (fe_a)
  );

  assign s_ch[0] = '{sum: 1'b0, first: fe_b.head, mode: fe_mode};
  assign b_ch[0] = fe_b;
  assign a_ch[0] = fe_a;

  generate
    for (genvar j = 0; j < C; j++) begin : g_cell
      sysmul_cell #(.W(W), .J(j), .LAST(j == C - 1)) cell_i (
        .clk   (clk),
        .rst   (rst),
        .s_in  (s_ch[j]),
        .b_in  (b_ch[j]),
        .a_in  (a_ch[j]),
        .s_out (s_ch[j+1]),
        .b_out (b_ch[j+1]),
        .a_out (a_ch[j+1])
      );
    end
  endgenerate

  assign prod_bit_o   = s_ch[C].sum;
  assign prod_first_o = s_ch[C].first;

  // Cycles since the most recent start, saturating; feeds the checks below.
  logic [SW-1:0] since_q;
  logic          op_b0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= SW'(LIM);
      op_b0_q <= 1'b0;
    end else begin
      if (start_i) since_q <= '0;
      else if (since_q < SW'(LIM)) since_q <= since_q + 1'b1;
      if (start_i) op_b0_q <= b_i;
    end
  end

  // R3: first-bit strobe arrives a fixed number of edges after start
  a_r3_first_latency: assert property (@(posedge clk) disable iff (rst)
    prod_first_o |-> (since_q == SW'(C)));

  // R3: strobe lasts one cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    prod_first_o |=> !prod_first_o);

  // R10: start pulses keep the minimum spacing
  a_r10_start_spacing: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (since_q >= SW'(LIM - 1)));

  // R6: operand and format reaching the tail match what was captured at start
  a_r6_tail_operands: assert property (@(posedge clk) disable iff (rst)
    prod_first_o |-> ((a_ch[C] == fe_a) && (s_ch[C].mode == fe_mode)));

  // R4: serial head leaves the chain on time carrying bit 0 of its operation
  generate
    if (3 * C < LIM) begin : g_tail_chk
      a_r4_tail_head: assert property (@(posedge clk) disable iff (rst)
        b_ch[C].head |-> ((since_q == SW'(3 * C)) && (b_ch[C].bit_v == op_b0_q)));
    end
  endgenerate

endmodule

// File: tb/sysmul_array_tb_top.sv
`timescale 1ns/1ps

module sysmul_array_tb_lane #(
  parameter int N = 8
) (
  input  logic clk,
  output logic done,
  output int   nvec,
  output int   nfail
);

  localparam int C = (N + 1) / 2;

  logic         rst, start, sgn, b;
  logic [N-1:0] a;
  logic         pbit, pfirst;
  int           tick;

  bit    exp_first [int];
  bit    exp_bit   [int];
  string exp_tag   [int];

  sysmul_array #(.N(N)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .signed_i     (sgn),
    .a_i          (a),
    .b_i          (b),
    .prod_bit_o   (pbit),
    .prod_first_o (pfirst)
  );

  // Advance to the next falling edge and compare against the model.
  task automatic step();
    @(negedge clk);
    tick++;
    nvec++;
    if (pfirst !== 1'(exp_first.exists(tick))) begin
      nfail++;
      $display("FAIL R3 N=%0d tick %0d: prod_first_o=%0b expected %0b",
               N, tick, pfirst, exp_first.exists(tick));
    end
    if (exp_bit.exists(tick)) begin
      nvec++;
      if (pbit !== exp_bit[tick]) begin
        nfail++;
        $display("FAIL %s N=%0d tick %0d: prod_bit_o=%0b expected %0b",
                 exp_tag[tick], N, tick, pbit, exp_bit[tick]);
      end
    end
  endtask

  task automatic run_op(input logic [N-1:0] av, input logic [N-1:0] bv,
                        input logic sg, input int gap, input string extra);
    longint x, y, p;
    string  tag;
    int     s;
    x = longint'(av);
    y = longint'(bv);
    if (sg && av[N-1]) x -= (64'sd1 <<< N);
    if (sg && bv[N-1]) y -= (64'sd1 <<< N);
    p = x * y;
    tag = sg ? "R2" : "R1";
    if (N % 2 == 1) tag = {tag, " R7"};
    tag = {tag, " R5 R6", extra};
    if (gap == 0) tag = {tag, " R4 R10"};
    s = tick;
    exp_first[s + C + 1] = 1'b1;
    for (int w = 0; w < 2 * N; w++) begin
      exp_bit[s + C + 1 + w] = p[w];
      exp_tag[s + C + 1 + w] = tag;
    end
    for (int i = 0; i < 2 * N; i++) begin
      start = (i == 0);
      // R5: slots N..2N-1 carry noise; R6: operand and mode noise after start
      b   = (i < N) ? bv[i] : 1'($urandom);
      a   = (i == 0) ? av : N'($urandom);
      sgn = (i == 0) ? sg : 1'($urandom);
      step();
    end
    for (int g = 0; g < gap; g++) begin
      start = 1'b0;
      b   = 1'($urandom);
      a   = N'($urandom);
      sgn = 1'($urandom);
      step();
    end
  endtask

  localparam logic [N-1:0] UMAX = {N{1'b1}};
  localparam logic [N-1:0] SMIN = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] SMAX = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] ONE  = N'(1);

  initial begin
    rst = 1'b1; start = 1'b0; sgn = 1'b0; a = '0; b = 1'b0;
    tick = 0; nvec = 0; nfail = 0; done = 1'b0;
    repeat (4) @(negedge clk);
    // R8: outputs quiet during reset
    nvec++;
    if (pbit !== 1'b0 || pfirst !== 1'b0) begin
      nfail++;
      $display("FAIL R8 N=%0d in reset: bit=%0b first=%0b expected 0 0", N, pbit, pfirst);
    end
    rst = 1'b0;
    step();
    // R8: outputs quiet after release
    nvec++;
    if (pbit !== 1'b0 || pfirst !== 1'b0) begin
      nfail++;
      $display("FAIL R8 N=%0d after reset: bit=%0b first=%0b expected 0 0", N, pbit, pfirst);
    end
    // R1 unsigned corners, R9 carries at their largest
    run_op('0, '0, 1'b0, 2, "");
    run_op(UMAX, UMAX, 1'b0, 0, " R9");
    run_op(ONE, UMAX, 1'b0, 0, "");
    run_op(UMAX, ONE, 1'b0, 3, "");
    // R2 signed corners
    run_op(SMIN, SMIN, 1'b1, 0, " R9");
    run_op(UMAX, UMAX, 1'b1, 0, "");
    run_op(SMIN, SMAX, 1'b1, 1, "");
    run_op(SMAX, SMIN, 1'b1, 0, "");
    run_op(UMAX, ONE, 1'b1, 0, "");
    run_op(SMAX, SMAX, 1'b1, 2, " R9");
    // Mixed-format back-to-back and random operations
    for (int k = 0; k < 40; k++) begin
      run_op(N'($urandom), N'($urandom), 1'($urandom), (k % 3 == 0) ? 0 : int'($urandom % 4), "");
    end
    start = 1'b0;
    repeat (C + 2 * N + 4) step();
    done = 1'b1;
  end

endmodule

module sysmul_array_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic d8, d5;
  int   v8, f8, v5, f5;

  sysmul_array_tb_lane #(.N(8)) lane8_i (.clk(clk), .done(d8), .nvec(v8), .nfail(f8));
  sysmul_array_tb_lane #(.N(5)) lane5_i (.clk(clk), .done(d5), .nvec(v5), .nfail(f5));

  initial begin
    int cyc;
    int wd;
    cyc = 0;
    wd  = 0;
    while (!(d8 === 1'b1 && d5 === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(d8 === 1'b1 && d5 === 1'b1)) begin
      wd = 1;
      $display("FAIL watchdog: run did not complete, cycles=%0d expected < 150000", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", v8 + v5 + wd, f8 + f5 + wd);
    $finish;
  end

endmodule